// File: doc/BRIEF.md
# Boundary-Scan Pin Chain with Per-Pin Drive Disable

This block is the boundary-scan register for a bank of general-purpose I/O pins. Each pin is served by a pair of scan cells. One is a drive-disable cell that decides whether the pin driver is enabled. The other is a bidirectional data cell that observes the pad and can also drive it. The pairs are linked into one serial chain between the test data input and the test data output. A test access port controller, which is outside this block, steps the chain with three single-cycle strobes: capture, shift and update. It also sets two level flags. The drive flag hands the pads to the scan latches. The float flag turns every driver off.

The core-side signals (output value, output enable) reach the pads unchanged when neither flag is set. The pad input is always passed back to the core. Every cell has a shift stage and a separate update latch. The pads therefore see only values that were committed with an update strobe, never bits that are still moving through the chain. After reset every drive-disable latch holds 1, so no pin is driven by the scan path.

Top module: `scan_pin_chain`

## Requirements
- R1: The chain holds 2*PINS cells (160 by default). Each shift strobe moves every cell one place toward the test data output. The top cell (index 2*PINS-1) takes tdi_i, and tdo_o always shows cell 0. A bit entered now appears at tdo_o after 2*PINS shift strobes.
- R2: For pin p, the drive-disable cell is at chain index 2p+1 and the data cell is at index 2p. The drive-disable cell therefore sits directly ahead of its data cell, on the side nearer tdi_i.
- R3: A capture strobe loads each drive-disable cell with the inverse of core_oe_i[p] (1 means disabled). It loads each data cell with pad_in_i[p].
- R4: Update latches change only on an update strobe, and then they copy their shift stages. Capture and shift strobes leave pad_out_o and pad_oe_o unchanged.
- R5: With drive_scan_i=1 and float_all_i=0, pad_oe_o[p] is the inverse of the drive-disable latch of pin p, and pad_out_o[p] is the data latch of pin p. A latch value of 1 in a drive-disable cell turns the pin driver off.
- R6: With drive_scan_i=0 and float_all_i=0, pad_out_o equals core_out_i and pad_oe_o equals core_oe_i, whatever the latches hold.
- R7: With float_all_i=1, every bit of pad_oe_o is 0, whatever the state of drive_scan_i.
- R8: A synchronous reset (rst_n low at a clock edge) sets every drive-disable shift stage and latch to 1 and every data shift stage and latch to 0. The result is pad_oe_o all zero in drive mode.
- R9: core_in_o always equals pad_in_i.
- R10: When capture and shift strobes arrive in the same cycle, capture wins and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all scan cells |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi_i | input | 1 | Serial data into the top of the chain |
| tdo_o | output | 1 | Serial data out of cell 0 |
| capture_i | input | 1 | Capture strobe, one cycle |
| shift_i | input | 1 | Shift strobe, one cycle per bit |
| update_i | input | 1 | Update strobe, one cycle |
| drive_scan_i | input | 1 | Pads take their value and enable from the update latches |
| float_all_i | input | 1 | Turns off every pad driver |
| core_out_i | input | PINS | Core output value for each pin |
| core_oe_i | input | PINS | Core output enable for each pin, 1 means drive |
| pad_in_i | input | PINS | Value seen at each pad |
| pad_out_o | output | PINS | Value driven toward each pad |
| pad_oe_o | output | PINS | Driver enable for each pad, 1 means drive |
| core_in_o | output | PINS | Pad value returned to the core |

## Verification
The assertions assume that the controller never raises update in the same cycle as shift. A real controller cannot do this, because the two strobes come from different controller states, and one assertion checks the assumption at the ports. Capture and shift may overlap, and the cell assertions then expect the capture value. The bench drives every strobe and flag on the falling edge as a single-cycle pulse. It never overlaps update with shift, and it overlaps capture with shift only in the one scenario that tests the overlap rule.

// File: rtl/scan_pkg.sv
// Package scan_pkg
// Shared types for the boundary-scan pin chain. It holds the pad source
// selection and the function that maps the controller flags onto it.
// It assumes that the float flag takes precedence over the drive flag.
package scan_pkg;

    // Which path owns a pad's value and enable.
    typedef enum logic [1:0] {
        PAD_CORE  = 2'd0,
        PAD_SCAN  = 2'd1,
        PAD_FLOAT = 2'd2
    } pad_src_e;

    // Maps the two controller flags to a pad source, with float on top.
    function automatic pad_src_e pick_pad_src(input logic drive_scan,
                                              input logic float_all);
        if (float_all)       return PAD_FLOAT;
        else if (drive_scan) return PAD_SCAN;
        else                 return PAD_CORE;
    endfunction

endpackage

// File: rtl/scan_cell.sv
// Module scan_cell
// One boundary-scan cell: a shift stage and a separate update latch.
// Capture loads cap_i and shift loads si_i. Capture wins if both arrive in
// the same cycle. The latch copies the shift stage only on update_i.
// Reset loads SAFE_VAL into both stages. It assumes that update_i never
// arrives in the same cycle as shift_i.
module scan_cell #(
    parameter logic SAFE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic capture_i,
    input  logic shift_i,
    input  logic update_i,
    input  logic cap_i,
    input  logic si_i,
    output logic so_o,
    output logic latch_o
);

    logic stage_q;
    logic latch_q;

    // Shift stage: capture has priority over shift, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         stage_q <= SAFE_VAL;
        else if (capture_i) stage_q <= cap_i;
        else if (shift_i)   stage_q <= si_i;
    end

    // Update latch: commits the shift stage only on the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= SAFE_VAL;
        else if (update_i) latch_q <= stage_q;
    end

    assign so_o    = stage_q;
    assign latch_o = latch_q;

    // R3: a capture lands the capture input in the stage.
    assert_capture_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> stage_q == $past(cap_i));

    // R1: a lone shift moves the neighbour's bit in.
    assert_shift_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !capture_i) |=> stage_q == $past(si_i));

    // R10: with capture and shift together, the shift input is not taken.
    assert_capture_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && capture_i && (cap_i != si_i)) |=> stage_q != $past(si_i));

    // R4: the latch holds without an update strobe.
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !update_i |=> $stable(latch_q));

    // R4: the latch takes the stage value on update.
    assert_latch_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        update_i |=> latch_q == $past(stage_q));

endmodule

// File: rtl/pin_slice.sv
// Module pin_slice
// Scan cells and pad steering for one I/O pin. The drive-disable cell comes
// first on the chain and feeds the data cell. The drive-disable cell safes
// to 1 (driver off) and the data cell safes to 0. The pad source is decoded
// once at the top and shared by all slices.
module pin_slice
    import scan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture_i,
    input  logic     shift_i,
    input  logic     update_i,
    input  pad_src_e pad_src_i,
    input  logic     si_i,
    output logic     so_o,
    input  logic     core_out_i,
    input  logic     core_oe_i,
    input  logic     pad_in_i,
    output logic     pad_out_o,
    output logic     pad_oe_o,
    output logic     core_in_o
);

    logic mid_link;
    logic disable_latch;
    logic data_latch;

    // Drive-disable cell: captures the core's disable state.
    scan_cell #(.SAFE_VAL(1'b1)) ctl_cell_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .update_i  (update_i),
        .cap_i     (~core_oe_i),
        .si_i      (si_i),
        .so_o      (mid_link),
        .latch_o   (disable_latch)
    );

    // Data cell: captures the pad and, in drive mode, drives it.
    scan_cell #(.SAFE_VAL(1'b0)) dat_cell_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .update_i  (update_i),
        .cap_i     (pad_in_i),
        .si_i      (mid_link),
        .so_o      (so_o),
        .latch_o   (data_latch)
    );

    // Pad steering: the core path, the scan latches, or all drivers off.
    always_comb begin
        case (pad_src_i)
            PAD_SCAN: begin
                pad_out_o = data_latch;
                pad_oe_o  = ~disable_latch;
            end
            PAD_CORE: begin
                pad_out_o = core_out_i;
                pad_oe_o  = core_oe_i;
            end
            default: begin
                pad_out_o = core_out_i;
                pad_oe_o  = 1'b0;
            end
        endcase
    end

    // The observed pad value always goes back to the core.
    assign core_in_o = pad_in_i;

endmodule

// File: rtl/scan_pin_chain.sv
// Module scan_pin_chain
// The boundary-scan register for PINS I/O pins, 2*PINS cells in all. Pin p
// owns chain cells 2p+1 (drive disable) and 2p (data). tdi_i enters at the
// top cell and tdo_o is cell 0. It assumes single-cycle strobes from a
// controller that never raises update together with shift.
module scan_pin_chain
    import scan_pkg::*;
#(
    parameter int PINS = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tdi_i,
    output logic            tdo_o,
    input  logic            capture_i,
    input  logic            shift_i,
    input  logic            update_i,
    input  logic            drive_scan_i,
    input  logic            float_all_i,
    input  logic [PINS-1:0] core_out_i,
    input  logic [PINS-1:0] core_oe_i,
    input  logic [PINS-1:0] pad_in_i,
    output logic [PINS-1:0] pad_out_o,
    output logic [PINS-1:0] pad_oe_o,
    output logic [PINS-1:0] core_in_o
);

    localparam int CELLS = 2 * PINS;

    pad_src_e        pad_src;
    logic [PINS:0]   link;

    // Decode the controller flags once for every slice.
    always_comb pad_src = pick_pad_src(drive_scan_i, float_all_i);

    // The top of the chain is fed from the serial input.
    assign link[PINS] = tdi_i;

    // One slice per pin, chained from the highest pin down to pin 0.
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pin_slice slice_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .capture_i  (capture_i),
            .shift_i    (shift_i),
            .update_i   (update_i),
            .pad_src_i  (pad_src),
            .si_i       (link[p+1]),
            .so_o       (link[p]),
            .core_out_i (core_out_i[p]),
            .core_oe_i  (core_oe_i[p]),
            .pad_in_i   (pad_in_i[p]),
            .pad_out_o  (pad_out_o[p]),
            .pad_oe_o   (pad_oe_o[p]),
            .core_in_o  (core_in_o[p])
        );
    end

    // Cell 0 drives the serial output.
    assign tdo_o = link[0];

    // R4: the controller never commits while shifting.
    assert_update_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(update_i && shift_i));

    // R7: the float flag silences every pad driver.
    assert_float_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        float_all_i |-> (pad_oe_o == '0));

    // R4: in drive mode with no update, the pads stay put from cycle to cycle.
    assert_pads_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_scan_i && !float_all_i && !update_i) |=>
        (($past(drive_scan_i) && !$past(float_all_i) && drive_scan_i && !float_all_i)
         -> ($stable(pad_oe_o) && $stable(pad_out_o))));

    // R1: the chain length matches the pin count.
    initial assert (CELLS == 2 * PINS && CELLS > 0);

endmodule

// File: tb/scan_pin_chain_tb.sv
// Directed bench for scan_pin_chain. Inputs are driven on falling edges and
// outputs are sampled there as well.
module scan_pin_chain_tb_top;

    localparam int PINS  = 80;
    localparam int CELLS = 2 * PINS;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tdi_i = 1'b0;
    logic            tdo_o;
    logic            capture_i = 1'b0;
    logic            shift_i = 1'b0;
    logic            update_i = 1'b0;
    logic            drive_scan_i = 1'b0;
    logic            float_all_i = 1'b0;
    logic [PINS-1:0] core_out_i = '0;
    logic [PINS-1:0] core_oe_i = '0;
    logic [PINS-1:0] pad_in_i = '0;
    logic [PINS-1:0] pad_out_o;
    logic [PINS-1:0] pad_oe_o;
    logic [PINS-1:0] core_in_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    scan_pin_chain #(.PINS(PINS)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tdi_i        (tdi_i),
        .tdo_o        (tdo_o),
        .capture_i    (capture_i),
        .shift_i      (shift_i),
        .update_i     (update_i),
        .drive_scan_i (drive_scan_i),
        .float_all_i  (float_all_i),
        .core_out_i   (core_out_i),
        .core_oe_i    (core_oe_i),
        .pad_in_i     (pad_in_i),
        .pad_out_o    (pad_out_o),
        .pad_oe_o     (pad_oe_o),
        .core_in_o    (core_in_o)
    );

    // Builds the chain image: the disable bit at 2p+1 and the data bit at 2p.
    function automatic logic [CELLS-1:0] weave(input logic [PINS-1:0] dis,
                                              input logic [PINS-1:0] dat);
        logic [CELLS-1:0] v;
        for (int p = 0; p < PINS; p++) begin
            v[2*p+1] = dis[p];
            v[2*p]   = dat[p];
        end
        return v;
    endfunction

    task automatic chk_wide(input string tag, input logic [CELLS-1:0] act,
                            input logic [CELLS-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag, input logic [PINS-1:0] act,
                            input logic [PINS-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Shifts din in, first bit din[0], and collects the old contents in dout.
    task automatic shift_chain(input logic [CELLS-1:0] din,
                               output logic [CELLS-1:0] dout);
        for (int i = 0; i < CELLS; i++) begin
            tdi_i   = din[i];
            shift_i = 1'b1;
            dout[i] = tdo_o;
            @(negedge clk);
        end
        shift_i = 1'b0;
        tdi_i   = 1'b0;
    endtask

    task automatic pulse_capture();
        capture_i = 1'b1;
        @(negedge clk);
        capture_i = 1'b0;
    endtask

    task automatic pulse_update();
        update_i = 1'b1;
        @(negedge clk);
        update_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R8: safe state after reset.
    task automatic t_reset_state();
        logic [CELLS-1:0] got;
        drive_scan_i = 1'b1;
        float_all_i  = 1'b0;
        #0;
        chk_pins("R8 reset pad_oe drive mode", pad_oe_o, '0);
        chk_pins("R8 reset pad_out drive mode", pad_out_o, '0);
        shift_chain('0, got);
        chk_wide("R8 R2 reset chain image", got, weave('1, '0));
    endtask

    // R3 R2: capture of the core disable state and the pad values.
    task automatic t_capture();
        logic [CELLS-1:0] got;
        core_oe_i = 80'h5A3C_0FF0_9E21_C48B_7D16;
        pad_in_i  = 80'hC3A5_1E07_F0B9_6D42_88E1;
        @(negedge clk);
        pulse_capture();
        core_oe_i = '0;
        pad_in_i  = '0;
        shift_chain('0, got);
        chk_wide("R3 R2 capture image", got,
                 weave(~80'h5A3C_0FF0_9E21_C48B_7D16, 80'hC3A5_1E07_F0B9_6D42_88E1));
    endtask

    // R1: a full chain length separates entry and exit.
    task automatic t_length();
        logic [CELLS-1:0] a;
        logic [CELLS-1:0] b;
        logic [CELLS-1:0] got;
        a = {80'h0123_4567_89AB_CDEF_FEDC, 80'hBA98_7654_3210_F00F_1EE1};
        b = ~a;
        shift_chain(a, got);
        shift_chain(b, got);
        chk_wide("R1 chain length round trip", got, a);
        chk_pins("R1 tdo shows cell 0", {{(PINS-1){1'b0}}, tdo_o}, {{(PINS-1){1'b0}}, b[0]});
    endtask

    // R4 R5: latches hold while shifting, then drive the pads after update.
    task automatic t_update_drive();
        logic [CELLS-1:0] got;
        logic [PINS-1:0]  dis;
        logic [PINS-1:0]  dat;
        dis = 80'hF0F0_A5A5_0000_FFFF_3C3C;
        dat = 80'h1234_5678_9ABC_DEF0_55AA;
        drive_scan_i = 1'b1;
        pulse_update();
        chk_pins("R5 first update disable", pad_oe_o, ~weave_dis(got_safe()));
        shift_chain(weave(dis, dat), got);
        pulse_capture();
        chk_pins("R4 pad_oe steady before update", pad_oe_o, ~weave_dis(got_safe()));
        shift_chain(weave(dis, dat), got);
        chk_pins("R4 pad_out steady before update", pad_out_o, weave_dat(got_safe()));
        pulse_update();
        chk_pins("R5 pad_oe from disable latches", pad_oe_o, ~dis);
        chk_pins("R5 pad_out from data latches", pad_out_o, dat);
    endtask

    // Chain image left by t_length (its second pattern) helpers.
    function automatic logic [CELLS-1:0] got_safe();
        logic [CELLS-1:0] a;
        a = {80'h0123_4567_89AB_CDEF_FEDC, 80'hBA98_7654_3210_F00F_1EE1};
        return ~a;
    endfunction

    function automatic logic [PINS-1:0] weave_dis(input logic [CELLS-1:0] v);
        logic [PINS-1:0] r;
        for (int p = 0; p < PINS; p++) r[p] = v[2*p+1];
        return r;
    endfunction

    function automatic logic [PINS-1:0] weave_dat(input logic [CELLS-1:0] v);
        logic [PINS-1:0] r;
        for (int p = 0; p < PINS; p++) r[p] = v[2*p];
        return r;
    endfunction

    // R6: normal mode follows the core regardless of latches.
    task automatic t_normal();
        drive_scan_i = 1'b0;
        core_out_i = 80'hDEAD_BEEF_0BAD_F00D_CAFE;
        core_oe_i  = 80'h0F1E_2D3C_4B5A_6978_8796;
        @(negedge clk);
        chk_pins("R6 pad_out follows core", pad_out_o, 80'hDEAD_BEEF_0BAD_F00D_CAFE);
        chk_pins("R6 pad_oe follows core", pad_oe_o, 80'h0F1E_2D3C_4B5A_6978_8796);
        core_out_i = ~core_out_i;
        core_oe_i  = '1;
        @(negedge clk);
        chk_pins("R6 pad_out second pattern", pad_out_o, ~80'hDEAD_BEEF_0BAD_F00D_CAFE);
        chk_pins("R6 pad_oe all enabled", pad_oe_o, '1);
    endtask

    // R7: float overrides both modes.
    task automatic t_float();
        float_all_i  = 1'b1;
        drive_scan_i = 1'b0;
        @(negedge clk);
        chk_pins("R7 float in normal mode", pad_oe_o, '0);
        drive_scan_i = 1'b1;
        @(negedge clk);
        chk_pins("R7 float in drive mode", pad_oe_o, '0);
        float_all_i = 1'b0;
        @(negedge clk);
        chk_pins("R7 drive restored after float", pad_oe_o, ~80'hF0F0_A5A5_0000_FFFF_3C3C);
    endtask

    // R9: pad input returns to the core in every mode.
    task automatic t_core_in();
        pad_in_i = 80'h9876_5432_10FE_DCBA_0F0F;
        @(negedge clk);
        chk_pins("R9 core_in drive mode", core_in_o, 80'h9876_5432_10FE_DCBA_0F0F);
        drive_scan_i = 1'b0;
        pad_in_i = 80'h1111_2222_3333_4444_5555;
        @(negedge clk);
        chk_pins("R9 core_in normal mode", core_in_o, 80'h1111_2222_3333_4444_5555);
        drive_scan_i = 1'b1;
    endtask

    // R10: capture wins over a simultaneous shift.
    task automatic t_priority();
        logic [CELLS-1:0] got;
        logic [CELLS-1:0] junk;
        shift_chain('1, junk);
        core_oe_i = 80'h00FF_00FF_00FF_00FF_00FF;
        pad_in_i  = 80'hAAAA_5555_AAAA_5555_AAAA;
        tdi_i     = 1'b1;
        capture_i = 1'b1;
        shift_i   = 1'b1;
        @(negedge clk);
        capture_i = 1'b0;
        shift_i   = 1'b0;
        tdi_i     = 1'b0;
        shift_chain('0, got);
        chk_wide("R10 capture beats shift", got,
                 weave(~80'h00FF_00FF_00FF_00FF_00FF, 80'hAAAA_5555_AAAA_5555_AAAA));
    endtask

    // R8: reset after use returns the latches to their safe values.
    task automatic t_reset_again();
        drive_scan_i = 1'b1;
        float_all_i  = 1'b0;
        do_reset();
        chk_pins("R8 reset clears loaded latches", pad_oe_o, '0);
        chk_pins("R8 reset clears data latches", pad_out_o, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_reset_state();
        t_capture();
        t_length();
        t_update_drive();
        t_normal();
        t_float();
        t_core_in();
        t_priority();
        t_reset_again();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule